// File: doc/BRIEF.md
# Boundary Scan Instruction Decoder and Data Register Selector

This block is the test logic that sits behind a test access port state machine. The state machine supplies one-cycle phase strobes: capture, shift and update, once for the instruction path and once for the data path. From these the block loads a 4-bit instruction, decodes it, and places one serial data register between `tdi` and `tdo`. The choices are a one-bit bypass stage, a 32-bit identification register, or a boundary register of two bits per output pin.

The decoded instruction also decides where each output pin gets its value and enable. The source is the core's own signals, the update stage of the boundary register, or nothing at all (enables forced low). A separate output tells an internal self-test engine to run while the self-test instruction is current. The test reset `trst_n` is active low and acts at once, without a clock edge. All registers are clocked on the rising edge of `tck`. The serial output changes on the falling edge.

Top module: `scan_instr_core`

## Requirements
- R1: While `trst_n` is low, with no clock edge needed, the current instruction becomes IDCODE (4'h2), `tdo_oe` is low, and the pins carry `core_data`/`core_oe`.
- R2: Capture-IR loads 4'b0001 into the instruction shift stage. Shift-IR moves bits in from `tdi` and out to `tdo`, least significant bit first. The current instruction changes only on Update-IR.
- R3: Codes: EXTEST 4'h0, SAMPLE/PRELOAD 4'h1, IDCODE 4'h2, USERCODE 4'h3, INTEST 4'h4, RUNBIST 4'h5, CLAMP 4'h6, HIGHZ 4'h7, BYPASS 4'hF. Every other code behaves exactly like BYPASS.
- R4: Under bypass the serial path is one bit long, and that bit captures 0 on Capture-DR.
- R5: IDCODE shifts out, LSB first, the word {version[3:0], part[15:0], maker[10:0], 1'b1}, packed from bit 31 down to bit 0.
- R6: USERCODE uses the same 32-bit path, but Capture-DR loads `user_code` into it instead of the fixed word.
- R7: The boundary register is 2*NPIN bits: bits [NPIN-1:0] hold pin data and bits [2*NPIN-1:NPIN] hold pin enables. Under SAMPLE/PRELOAD, Capture-DR snapshots {`core_oe`,`core_data`} and Update-DR copies the shift stage into the update stage. The pins keep following the core throughout.
- R8: EXTEST and INTEST put the boundary register on the serial path and drive the pins from its update stage.
- R9: CLAMP drives the pins from the update stage while the serial path is the bypass bit.
- R10: HIGHZ drives every pin enable low, and the serial path is the bypass bit.
- R11: RUNBIST raises `bist_run`, drives the pins from the update stage, and uses the bypass bit as the serial path.
- R12: `tdo` changes only on the falling edge of `tck`. `tdo_oe` is high only in a cycle with Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial test data in |
| capture_ir | input | 1 | Capture-IR phase strobe |
| shift_ir | input | 1 | Shift-IR phase strobe |
| update_ir | input | 1 | Update-IR phase strobe |
| capture_dr | input | 1 | Capture-DR phase strobe |
| shift_dr | input | 1 | Shift-DR phase strobe |
| update_dr | input | 1 | Update-DR phase strobe |
| user_code | input | 32 | User-programmable code captured under USERCODE |
| core_data | input | NPIN | Output values produced by the core |
| core_oe | input | NPIN | Output enables produced by the core |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Drive enable for `tdo` |
| pin_out | output | NPIN | Value sent to the output pins |
| pin_oe | output | NPIN | Enable sent to the output pins |
| bist_run | output | 1 | Self-test start level, high under RUNBIST |

## Verification
Two functions can act in the same sequence: loading the boundary update stage while the core still owns the pins (PRELOAD), and an Update-IR that hands the pins over to that stage. The bench preloads a known pattern under SAMPLE/PRELOAD. It checks that the pins still follow the core, including after the core changes its values. It then loads EXTEST and expects the preloaded data and enables on the pins straight after the instruction update edge. A test reset given mid-cycle under EXTEST must give the pins back to the core with no clock edge.

// File: rtl/scan_instr_pkg.sv
package scan_instr_pkg;
  localparam int IR_W = 4;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST   = 4'h0;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 4'h1;
  localparam logic [IR_W-1:0] OP_IDCODE   = 4'h2;
  localparam logic [IR_W-1:0] OP_USERCODE = 4'h3;
  localparam logic [IR_W-1:0] OP_INTEST   = 4'h4;
  localparam logic [IR_W-1:0] OP_RUNBIST  = 4'h5;
  localparam logic [IR_W-1:0] OP_CLAMP    = 4'h6;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 4'h7;
  localparam logic [IR_W-1:0] OP_BYPASS   = 4'hF;

  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 4'b0001;

  typedef enum logic [1:0] {
    PATH_BYP = 2'd0,
    PATH_ID  = 2'd1,
    PATH_BSR = 2'd2
  } path_e;

  typedef enum logic [1:0] {
    DRV_SYS = 2'd0,
    DRV_BSR = 2'd1,
    DRV_OFF = 2'd2
  } drive_e;

  typedef struct packed {
    path_e  path;
    drive_e drive;
    logic   use_user;
    logic   bist_run;
  } dec_t;
endpackage

// File: rtl/scan_ir.sv
module scan_ir
  import scan_instr_pkg::*;
#(
  parameter logic [IR_W-1:0] RST_OP = OP_IDCODE
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            capture_ir,
  input  logic            shift_ir,
  input  logic            update_ir,
  output logic [IR_W-1:0] ir_sh_q,
  output logic [IR_W-1:0] ir_q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh_q <= IR_CAPTURE_PAT;
    end else if (capture_ir) begin
      ir_sh_q <= IR_CAPTURE_PAT;
    end else if (shift_ir) begin
      ir_sh_q <= {tdi, ir_sh_q[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_q <= RST_OP;
    end else if (update_ir) begin
      ir_q <= ir_sh_q;
    end
  end
endmodule

// File: rtl/scan_decode.sv
module scan_decode
  import scan_instr_pkg::*;
#(
  parameter bit HAS_IDREG = 1'b1
) (
  input  logic [IR_W-1:0] op,
  output dec_t            dec
);
  always_comb begin
    dec = '{path: PATH_BYP, drive: DRV_SYS, use_user: 1'b0, bist_run: 1'b0};
    unique case (op)
      OP_EXTEST, OP_INTEST: begin
        dec.path  = PATH_BSR;
        dec.drive = DRV_BSR;
      end
      OP_SAMPLE: dec.path = PATH_BSR;
      OP_IDCODE: if (HAS_IDREG) dec.path = PATH_ID;
      OP_USERCODE: if (HAS_IDREG) begin
        dec.path     = PATH_ID;
        dec.use_user = 1'b1;
      end
      OP_RUNBIST: begin
        dec.drive    = DRV_BSR;
        dec.bist_run = 1'b1;
      end
      OP_CLAMP: dec.drive = DRV_BSR;
      OP_HIGHZ: dec.drive = DRV_OFF;
      default: ;
    endcase
  end
endmodule

// File: rtl/scan_dr_bank.sv
module scan_dr_bank
  import scan_instr_pkg::*;
#(
  parameter int              NPIN      = 4,
  parameter bit              HAS_IDREG = 1'b1,
  parameter logic [ID_W-1:0] ID_WORD   = 32'h1,
  localparam int             BSR_W     = 2 * NPIN
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  path_e            path,
  input  logic             use_user,
  input  logic [ID_W-1:0]  user_code,
  input  logic [NPIN-1:0]  core_data,
  input  logic [NPIN-1:0]  core_oe,
  output logic             dr_so,
  output logic [BSR_W-1:0] upd_q
);
  logic             byp_q;
  logic             id_so;
  logic [BSR_W-1:0] bsr_sh_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
    end else if (path == PATH_BYP) begin
      if (capture_dr)    byp_q <= 1'b0;
      else if (shift_dr) byp_q <= tdi;
    end
  end

  generate
    if (HAS_IDREG) begin : g_id
      logic [ID_W-1:0] id_sh_q;
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
          id_sh_q <= ID_WORD;
        end else if (path == PATH_ID) begin
          if (capture_dr)    id_sh_q <= use_user ? user_code : ID_WORD;
          else if (shift_dr) id_sh_q <= {tdi, id_sh_q[ID_W-1:1]};
        end
      end
      assign id_so = id_sh_q[0];
    end else begin : g_no_id
      logic unused_id;
      assign unused_id = ^{use_user, user_code};
      assign id_so     = 1'b0;
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      bsr_sh_q <= '0;
    end else if (path == PATH_BSR) begin
      if (capture_dr)    bsr_sh_q <= {core_oe, core_data};
      else if (shift_dr) bsr_sh_q <= {tdi, bsr_sh_q[BSR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      upd_q <= '0;
    end else if (update_dr && path == PATH_BSR) begin
      upd_q <= bsr_sh_q;
    end
  end

  always_comb begin
    unique case (path)
      PATH_ID:  dr_so = id_so;
      PATH_BSR: dr_so = bsr_sh_q[0];
      default:  dr_so = byp_q;
    endcase
  end
endmodule

// File: rtl/scan_pin_mux.sv
module scan_pin_mux
  import scan_instr_pkg::*;
#(
  parameter int NPIN = 4
) (
  input  drive_e            drive,
  input  logic [NPIN-1:0]   core_data,
  input  logic [NPIN-1:0]   core_oe,
  input  logic [2*NPIN-1:0] upd,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe
);
  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      always_comb begin
        unique case (drive)
          DRV_BSR: begin
            pin_out[i] = upd[i];
            pin_oe[i]  = upd[NPIN+i];
          end
          DRV_OFF: begin
            pin_out[i] = core_data[i];
            pin_oe[i]  = 1'b0;
          end
          default: begin
            pin_out[i] = core_data[i];
            pin_oe[i]  = core_oe[i];
          end
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/scan_instr_core.sv
module scan_instr_core
  import scan_instr_pkg::*;
#(
  parameter int           NPIN      = 4,
  parameter bit           HAS_IDREG = 1'b1,
  parameter logic [3:0]   VERSION   = 4'h1,
  parameter logic [15:0]  PART_NO   = 16'h5A3C,
  parameter logic [10:0]  MAKER_ID  = 11'h0A5
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            capture_ir,
  input  logic            shift_ir,
  input  logic            update_ir,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic [31:0]     user_code,
  input  logic [NPIN-1:0] core_data,
  input  logic [NPIN-1:0] core_oe,
  output logic            tdo,
  output logic            tdo_oe,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            bist_run
);
  localparam logic [ID_W-1:0] ID_WORD = {VERSION, PART_NO, MAKER_ID, 1'b1};
  localparam logic [IR_W-1:0] RST_OP  = HAS_IDREG ? OP_IDCODE : OP_BYPASS;
  localparam int              BSR_W   = 2 * NPIN;

  logic [IR_W-1:0]  ir_sh_q;
  logic [IR_W-1:0]  cur_op;
  dec_t             dec;
  logic             dr_so;
  logic [BSR_W-1:0] upd_q;

  scan_ir #(.RST_OP(RST_OP)) u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
    .ir_sh_q(ir_sh_q), .ir_q(cur_op)
  );

  scan_decode #(.HAS_IDREG(HAS_IDREG)) u_dec (
    .op(cur_op), .dec(dec)
  );

  scan_dr_bank #(.NPIN(NPIN), .HAS_IDREG(HAS_IDREG), .ID_WORD(ID_WORD)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .path(dec.path), .use_user(dec.use_user), .user_code(user_code),
    .core_data(core_data), .core_oe(core_oe),
    .dr_so(dr_so), .upd_q(upd_q)
  );

  scan_pin_mux #(.NPIN(NPIN)) u_pins (
    .drive(dec.drive), .core_data(core_data), .core_oe(core_oe),
    .upd(upd_q), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign bist_run = dec.bist_run;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= shift_ir | shift_dr;
      if (shift_ir)      tdo <= ir_sh_q[0];
      else if (shift_dr) tdo <= dr_so;
    end
  end
endmodule

// File: rtl/scan_instr_chk.sv
module scan_instr_chk
  import scan_instr_pkg::*;
#(
  parameter int NPIN = 4
) (
  input logic              tck,
  input logic              trst_n,
  input logic              capture_ir,
  input logic              update_ir,
  input logic              capture_dr,
  input logic              shift_ir,
  input logic              shift_dr,
  input logic              update_dr,
  input logic [IR_W-1:0]   cur_op,
  input logic [IR_W-1:0]   ir_sh_q,
  input logic [1:0]        path,
  input logic              dr_so,
  input logic [2*NPIN-1:0] upd_q,
  input logic              tdo_oe,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic [NPIN-1:0]   core_data,
  input logic [NPIN-1:0]   core_oe
);
  a_r2_ir_capture: assert property (@(posedge tck) disable iff (!trst_n)
    capture_ir |=> ir_sh_q == IR_CAPTURE_PAT);

  a_r2_ir_hold: assert property (@(posedge tck) disable iff (!trst_n)
    !update_ir |=> $stable(cur_op));

  a_r4_byp_capture: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && path == PATH_BYP && !update_ir) |=> !dr_so);

  a_r7_sample_pins: assert property (@(posedge tck) disable iff (!trst_n)
    cur_op == OP_SAMPLE |-> (pin_out == core_data && pin_oe == core_oe));

  a_r7_upd_hold: assert property (@(posedge tck) disable iff (!trst_n)
    !update_dr |=> $stable(upd_q));

  a_r10_highz_off: assert property (@(posedge tck) disable iff (!trst_n)
    cur_op == OP_HIGHZ |-> pin_oe == '0);

  a_r12_tdo_off: assert property (@(posedge tck) disable iff (!trst_n)
    (!shift_ir && !shift_dr) |-> !tdo_oe);
endmodule

bind scan_instr_core scan_instr_chk #(.NPIN(NPIN)) u_chk (
  .tck(tck), .trst_n(trst_n),
  .capture_ir(capture_ir), .update_ir(update_ir),
  .capture_dr(capture_dr), .shift_ir(shift_ir), .shift_dr(shift_dr),
  .update_dr(update_dr), .cur_op(cur_op), .ir_sh_q(ir_sh_q),
  .path(dec.path), .dr_so(dr_so), .upd_q(upd_q), .tdo_oe(tdo_oe),
  .pin_out(pin_out), .pin_oe(pin_oe), .core_data(core_data), .core_oe(core_oe)
);

// File: tb/tb_scan_instr_core.sv
`timescale 1ns/1ps
module tb_scan_instr_core;
  localparam int NPIN = 4;
  localparam logic [31:0] EXP_ID = {4'h1, 16'h5A3C, 11'h0A5, 1'b1};
  localparam logic [5:0] S_CIR = 6'b100000, S_SIR = 6'b010000, S_UIR = 6'b001000;
  localparam logic [5:0] S_CDR = 6'b000100, S_SDR = 6'b000010, S_UDR = 6'b000001;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tdi = 1'b0;
  logic capture_ir = 0, shift_ir = 0, update_ir = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0;
  logic [31:0] user_code = 32'hDEADBEEF;
  logic [NPIN-1:0] core_data = 4'b1010, core_oe = 4'b1100;
  logic tdo, tdo_oe, bist_run;
  logic [NPIN-1:0] pin_out, pin_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 tck = ~tck;

  scan_instr_core #(.NPIN(NPIN)) dut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .user_code(user_code), .core_data(core_data), .core_oe(core_oe),
    .tdo(tdo), .tdo_oe(tdo_oe), .pin_out(pin_out), .pin_oe(pin_oe),
    .bist_run(bist_run)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] strb, input logic d, output logic o, output logic oe);
    {capture_ir, shift_ir, update_ir, capture_dr, shift_dr, update_dr} = strb;
    tdi = d;
    @(negedge tck); #1;
    o = tdo; oe = tdo_oe;
    @(posedge tck); #1;
    if (strb == S_SIR || strb == S_SDR) chk("R12 tdo held past rising edge", {31'd0, tdo}, {31'd0, o});
    {capture_ir, shift_ir, update_ir, capture_dr, shift_dr, update_dr} = '0;
  endtask

  task automatic scan_ir(input logic [3:0] op, input bit upd, output logic [3:0] cap);
    logic o, oe;
    step(S_CIR, 1'b0, o, oe);
    for (int i = 0; i < 4; i++) begin
      step(S_SIR, op[i], o, oe);
      cap[i] = o;
    end
    if (upd) step(S_UIR, 1'b0, o, oe);
  endtask

  task automatic load_op(input logic [3:0] op);
    logic [3:0] cap;
    scan_ir(op, 1'b1, cap);
    chk("R2 captured IR pattern", {28'd0, cap}, 32'h1);
  endtask

  task automatic scan_dr(input int len, input logic [31:0] din, output logic [31:0] dout);
    logic o, oe;
    dout = '0;
    step(S_CDR, 1'b0, o, oe);
    chk("R12 tdo_oe low in capture", {31'd0, oe}, 32'd0);
    for (int i = 0; i < len; i++) begin
      step(S_SDR, din[i], o, oe);
      dout[i] = o;
    end
    step(S_UDR, 1'b0, o, oe);
  endtask

  task automatic pins(input string req, input logic [3:0] d, input logic [3:0] e);
    chk({req, " pin_out"}, {28'd0, pin_out}, {28'd0, d});
    chk({req, " pin_oe"},  {28'd0, pin_oe},  {28'd0, e});
  endtask

  task automatic byp_path(input string req);
    logic [31:0] q;
    scan_dr(8, 32'hB4, q);
    chk(req, q & 32'hFF, {24'd0, 7'h34, 1'b0});
  endtask

  task automatic t_reset;
    chk("R1 tdo_oe in reset", {31'd0, tdo_oe}, 0);
    pins("R1 reset", core_data, core_oe);
    @(posedge tck); #1 trst_n = 1'b1;
  endtask

  task automatic t_idcode;
    logic [31:0] q;
    scan_dr(32, 32'h0, q);
    chk("R5 IDCODE word after reset (R1)", q, EXP_ID);
  endtask

  task automatic t_ir_no_update;
    logic [3:0] cap;
    logic [31:0] q;
    scan_ir(4'hF, 1'b0, cap);
    chk("R2 IR capture 0001", {28'd0, cap}, 32'h1);
    scan_dr(32, 32'h0, q);
    chk("R2 no change without Update-IR", q, EXP_ID);
  endtask

  task automatic t_bypass;
    load_op(4'hF);
    byp_path("R4 bypass one bit captures 0");
    load_op(4'hA);
    byp_path("R3 undefined code acts as bypass");
  endtask

  task automatic t_user;
    logic [31:0] q;
    load_op(4'h3);
    scan_dr(32, 32'h0, q);
    chk("R6 USERCODE captured", q, 32'hDEADBEEF);
  endtask

  task automatic t_sample;
    logic [31:0] q;
    load_op(4'h1);
    scan_dr(8, 32'h5F, q);
    chk("R7 SAMPLE snapshot", q & 32'hFF, 32'hCA);
    pins("R7 pins follow core after preload", 4'b1010, 4'b1100);
    core_data = 4'b0110; #1;
    pins("R7 pins follow core change", 4'b0110, 4'b1100);
  endtask

  task automatic t_extest;
    logic [31:0] q;
    load_op(4'h0);
    pins("R8 EXTEST preloaded", 4'hF, 4'h5);
    scan_dr(8, 32'h3C, q);
    chk("R8 EXTEST boundary path", q & 32'hFF, 32'hC6);
    pins("R8 EXTEST updated", 4'hC, 4'h3);
  endtask

  task automatic t_intest;
    logic [31:0] q;
    load_op(4'h4);
    pins("R8 INTEST drives from update stage", 4'hC, 4'h3);
    scan_dr(8, 32'h96, q);
    chk("R8 INTEST boundary path", q & 32'hFF, 32'hC6);
    pins("R8 INTEST updated", 4'h6, 4'h9);
  endtask

  task automatic t_clamp;
    load_op(4'h6);
    byp_path("R9 CLAMP bypass path");
    pins("R9 CLAMP pins", 4'h6, 4'h9);
  endtask

  task automatic t_highz;
    load_op(4'h7);
    chk("R10 HIGHZ enables off", {28'd0, pin_oe}, 0);
    byp_path("R10 HIGHZ bypass path");
  endtask

  task automatic t_runbist;
    load_op(4'h5);
    chk("R11 bist_run high", {31'd0, bist_run}, 1);
    pins("R11 RUNBIST pins", 4'h6, 4'h9);
    byp_path("R11 RUNBIST bypass path");
    load_op(4'hF);
    chk("R11 bist_run low after bypass", {31'd0, bist_run}, 0);
    pins("R3 bypass returns pins to core", core_data, core_oe);
  endtask

  task automatic t_trst;
    logic [31:0] q;
    load_op(4'h0);
    pins("R8 EXTEST before reset", 4'h6, 4'h9);
    #1 trst_n = 1'b0; #1;
    pins("R1 async reset gives pins to core", core_data, core_oe);
    @(posedge tck); #1 trst_n = 1'b1;
    scan_dr(32, 32'h0, q);
    chk("R1 IDCODE after reset", q, EXP_ID);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge tck);
    #1;
    t_reset;
    t_idcode;
    t_ir_no_update;
    t_bypass;
    t_user;
    t_sample;
    t_extest;
    t_intest;
    t_clamp;
    t_highz;
    t_runbist;
    t_trst;
    finish_run;
  end

  initial begin
    #(8 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule